// File: doc/BRIEF.md
# Digital Input Monitor with Hold Timers

This block watches ten digital input pins and drives eight digital output pins. Eight of the inputs are plain buttons. The block reports the level of each one and raises a sticky interrupt flag whenever that level rises or falls. The other two inputs are hold inputs. While a hold input is pressed, a timer counts clock cycles. When the input is released, the count is latched into a readable register and a single flag is raised. All ten flags are ORed onto one interrupt line.

Software reaches the block through a simple register port: a write strobe with a 2-bit address and 32 bits of data, and a separate read address with combinational read data. Every input first passes through a two-flop synchronizer.

Each hold timer is a small state machine with two states. State HT_IDLE waits for a press. The transition HT_IDLE to HT_HELD happens on the press and clears the counter. State HT_HELD counts up and saturates at the top of the counter. The transition HT_HELD to HT_HELD is taken while the input stays high. The transition HT_HELD to HT_IDLE happens on the release: it latches the count and sends a one-cycle release pulse to the flag bank. The transition HT_IDLE to HT_IDLE is taken while the input stays low.

Top module: `dio_monitor`

## Requirements
- R1: After reset, register 0 reads 0, registers 1 and 2 read 0, all output pins are 0 and the interrupt line is 0.
- R2: Register 0 bits 7:0 show the synchronized level of plain inputs `din[7:0]`, with bit i carrying `din[i]`. A change becomes visible at most three clocks after it reaches the pin.
- R3: A rising or a falling level on plain input `din[i]` (i from 0 to 7) sets flag bit 16+i of register 0.
- R4: Hold inputs `din[8]` and `din[9]` set flag bits 24 and 25 only on release. A press, and the time the input is held, leave the flag unchanged.
- R5: On release, register 1 (for `din[8]`) or register 2 (for `din[9]`) receives the hold count, zero-extended to 32 bits. The hold count equals the number of clock edges at which the pin was high, minus one.
- R6: The hold count saturates at 2^HOLD_W-1 and does not wrap.
- R7: Writing address 0 with a 1 in any of bits 25:16 clears those flags. Flag bits written as 0 keep their value.
- R8: A new event for a flag in the same cycle as a clear of that flag leaves the flag set.
- R9: `irq` is high exactly when at least one of the ten flags is set.
- R10: A write to address 0 loads bits 15:8 onto `dout[7:0]`, and these bits read back in register 0. Writes to bits 7:0 of address 0, and writes to addresses 1 and 2, have no effect.
- R11: A latched hold count keeps its value until the next release of the same input, including while a new press is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 10 | Raw inputs; [7:0] plain, [8] and [9] hold |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data for rd_addr |
| dout | output | 8 | Digital output pins |
| irq | output | 1 | OR of all flags |

## Verification
The plain inputs are driven with single rising edges, single falling edges, and changes on several pins at once.
- Single edges show that each pin maps to its own flag bit.
- Changes on several pins at once show that flags do not leak between bits.

The hold inputs are driven with presses of several lengths: a one-cycle tap, a ten-cycle press, and a press long enough to hit the saturation limit.
- These lengths fix the off-by-one rule of the count and show saturation rather than wrap.
- A flag read taken mid-press separates flagging on release from flagging on press.

A clear written in the same cycle as a fresh edge separates event priority from clear priority.

// File: rtl/dio_pkg.sv
package dio_pkg;
    // Register map field positions (decoded by software)
    localparam int LVL_LSB  = 0;
    localparam int OUT_LSB  = 8;
    localparam int FLAG_LSB = 16;

    typedef enum logic [0:0] {
        HT_IDLE = 1'b0,
        HT_HELD = 1'b1
    } ht_state_e;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dio_edge_det.sv
module dio_edge_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    // Any change of level, rising or falling, is an event
    assign evt_o = lvl_i ^ prev_q;
endmodule

// File: rtl/dio_hold_timer.sv
module dio_hold_timer
    import dio_pkg::*;
#(
    parameter int HOLD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_i,
    output logic [HOLD_W-1:0] latched_o,
    output logic              release_o
);
    localparam logic [HOLD_W-1:0] CNT_MAX = '1;

    ht_state_e         state_q, state_d;
    logic [HOLD_W-1:0] cnt_q;
    logic [HOLD_W-1:0] latched_q;
    logic              release_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HT_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HT_IDLE: state_d = lvl_i ? HT_HELD : HT_IDLE;
            HT_HELD: state_d = lvl_i ? HT_HELD : HT_IDLE;
            default: state_d = HT_IDLE;
        endcase
    end

    // Datapath and outputs driven by the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            latched_q <= '0;
            release_q <= 1'b0;
        end else begin
            release_q <= 1'b0;
            unique case (state_q)
                HT_IDLE: begin
                    if (lvl_i) cnt_q <= '0;
                end
                HT_HELD: begin
                    if (lvl_i) begin
                        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    end else begin
                        latched_q <= cnt_q;
                        release_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign latched_o = latched_q;
    assign release_o = release_q;

    assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HT_HELD && lvl_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HT_HELD && lvl_i && cnt_q != CNT_MAX) |=>
            (cnt_q == HOLD_W'($past(cnt_q) + 1'b1)));

    assert_latch_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == HT_HELD && !lvl_i) |=> $stable(latched_o));

    assert_release_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !release_o);
endmodule

// File: rtl/dio_flag_bank.sv
module dio_flag_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    // Events win over clears in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_i) | evt_i;
    end

    assign flag_o = flag_q;

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> flag_o[g]);
        assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[g] && !clr_i[g]) |=> flag_o[g]);
        assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_o[g] && !evt_i[g]) |=> !flag_o[g]);
    end
endmodule

// File: rtl/dio_monitor.sv
module dio_monitor
    import dio_pkg::*;
#(
    parameter int N_PLAIN     = 8,
    parameter int N_HOLD      = 2,
    parameter int HOLD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  din,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic [7:0]  dout,
    output logic        irq
);
    localparam int N_IN = N_PLAIN + N_HOLD;

    logic [N_IN-1:0]    lvl;
    logic [N_PLAIN-1:0] plain_evt;
    logic [N_HOLD-1:0]  hold_rel;
    logic [HOLD_W-1:0]  hold_cnt [N_HOLD];
    logic [N_IN-1:0]    flags;
    logic [N_IN-1:0]    clr;
    logic [7:0]         out_q;
    logic               wr0;
    logic               unused_wr;

    dio_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(din), .q(lvl)
    );

    dio_edge_det #(.W(N_PLAIN)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl[N_PLAIN-1:0]), .evt_o(plain_evt)
    );

    for (genvar h = 0; h < N_HOLD; h++) begin : g_hold
        dio_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
            .clk(clk), .rst_n(rst_n), .lvl_i(lvl[N_PLAIN+h]),
            .latched_o(hold_cnt[h]), .release_o(hold_rel[h])
        );
    end

    assign wr0 = wr_en && (wr_addr == 2'd0);
    assign clr = wr0 ? wr_data[FLAG_LSB +: N_IN] : '0;

    dio_flag_bank #(.N(N_IN)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_i({hold_rel, plain_evt}),
        .clr_i(clr), .flag_o(flags)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)   out_q <= '0;
        else if (wr0) out_q <= wr_data[OUT_LSB +: 8];
    end

    assign unused_wr = ^{wr_data[31:FLAG_LSB+N_IN], wr_data[OUT_LSB-1:0]};

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            2'd0: begin
                rd_data[LVL_LSB +: N_PLAIN] = lvl[N_PLAIN-1:0];
                rd_data[OUT_LSB +: 8]       = out_q;
                rd_data[FLAG_LSB +: N_IN]   = flags;
            end
            2'd1:    rd_data = 32'(hold_cnt[0]);
            2'd2:    rd_data = 32'(hold_cnt[1]);
            default: rd_data = '0;
        endcase
    end

    assign dout = out_q;
    assign irq  = |flags;

    assert_out_only_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr0 |=> $stable(dout));

    assert_irq_has_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd0) |-> (irq == (rd_data[FLAG_LSB +: N_IN] != '0)));
endmodule

// File: tb/dio_monitor_tb.sv
module dio_monitor_tb_top;
    localparam int HW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  din = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  dout;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dio_monitor #(.HOLD_W(HW)) dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dout(dout), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v); chk("R1 reg0 after reset", v, 32'h0);
        rd(2'd1, v); chk("R1 reg1 after reset", v, 32'h0);
        rd(2'd2, v); chk("R1 reg2 after reset", v, 32'h0);
        chk("R1 dout after reset", {24'h0, dout}, 32'h0);
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_plain_edges;
        logic [31:0] v;
        din[0] = 1'b1; tick(4);
        rd(2'd0, v);
        chk("R2 level bit0", {24'h0, v[7:0]}, 32'h01);
        chk("R3 rise flag bit16", {22'h0, v[25:16]}, 32'h001);
        chk("R9 irq with one flag", {31'h0, irq}, 32'h1);
        wr(2'd0, 32'h0001_0000);
        rd(2'd0, v); chk("R7 clear bit16", {22'h0, v[25:16]}, 32'h0);
        chk("R9 irq low after clear", {31'h0, irq}, 32'h0);
        din[5] = 1'b1; din[2] = 1'b1; din[0] = 1'b0; tick(4);
        rd(2'd0, v);
        chk("R2 levels multi", {24'h0, v[7:0]}, 32'h24);
        chk("R3 fall and rise flags", {22'h0, v[25:16]}, 32'h025);
        wr(2'd0, 32'h0004_0000);
        rd(2'd0, v); chk("R7 partial clear keeps others", {22'h0, v[25:16]}, 32'h021);
        wr(2'd0, 32'h03FF_0000);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        din[7] = 1'b1; tick(4);
        din[7] = 1'b0;
        tick(2);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h0080_0000;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
        rd(2'd0, v); chk("R8 event beats clear", {31'h0, v[23]}, 32'h1);
        wr(2'd0, 32'h0080_0000);
        rd(2'd0, v); chk("R7 clear after collision", {22'h0, v[25:16]}, 32'h0);
    endtask

    task automatic t_outputs;
        logic [31:0] v;
        wr(2'd0, 32'h0000_A5FF);
        chk("R10 dout from write", {24'h0, dout}, 32'hA5);
        rd(2'd0, v);
        chk("R10 readback and bits 7:0 ignored", v, 32'h0000_A524);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h1234_5678);
        rd(2'd1, v); chk("R10 reg1 write ignored", v, 32'h0);
        rd(2'd2, v); chk("R10 reg2 write ignored", v, 32'h0);
        chk("R10 dout unchanged by other writes", {24'h0, dout}, 32'hA5);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        din[8] = 1'b1; tick(10);
        rd(2'd0, v); chk("R4 no flag while held", {31'h0, v[24]}, 32'h0);
        din[8] = 1'b0; tick(6);
        rd(2'd1, v); chk("R5 count after 10 cycles", v, 32'd9);
        rd(2'd0, v); chk("R4 flag on release", {22'h0, v[25:16]}, 32'h100);
        wr(2'd0, 32'h0100_0000);
        din[9] = 1'b1; tick(1); din[9] = 1'b0; tick(6);
        rd(2'd2, v); chk("R5 one-cycle tap", v, 32'd0);
        rd(2'd0, v); chk("R4 flag bit25 on release", {22'h0, v[25:16]}, 32'h200);
        wr(2'd0, 32'h0200_0000);
        din[8] = 1'b1; tick(30);
        rd(2'd1, v); chk("R11 latched value kept during new hold", v, 32'd9);
        tick(70);
        din[8] = 1'b0; tick(6);
        rd(2'd1, v); chk("R6 saturated count", v, 32'd63);
        wr(2'd0, 32'h0100_0000);
        chk("R9 irq low after all cleared", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_plain_edges();
        t_collision();
        t_outputs();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule